// File: doc/BRIEF.md
# Dual-Path SPI Bit-Clock Divider

This block turns a single fast source clock into the serial bit clock of an SPI master. No second clock domain is involved. It runs entirely on the source clock. Its outputs are a registered serial clock level and a one-cycle toggle pulse. The pulse marks every cycle in which the serial clock changes level, so the shift logic of the transfer engine can use it as a clock enable.

There are two divider paths, and one select input chooses between them.

- The power-of-two path divides by 4 and then by 2 to the power of an exponent field. The full division is 2^(E+2).
- The linear path divides by 2 and then by (N+1), taken from an 8-bit field. The full division is 2*(N+1).

Both divisions are even, so the serial clock always has a 50% duty cycle. In source cycles, each half period is 2^(E+1) on the power-of-two path and N+1 on the linear path.

The divider runs only while the transfer-enable input is high. While that input is low:

- no toggle pulses come out;
- the serial clock rests at the programmed idle polarity;
- the divisor and polarity inputs are tracked.

On the first cycle of a transfer, the divisor and polarity are frozen and the half-period counter restarts from zero. The first edge therefore comes one full half period later. Divisor changes made during a transfer have no effect until the next idle period.

Top module: `sclk_dual_div`

## Requirements
- R1: While rst_n is low, sclk and sclk_tick are both 0.
- R2: While the transfer is idle, sclk_tick stays 0. The transfer is idle in any cycle that follows a rising clock edge at which xfer_en was sampled 0.
- R3: With lin_sel = 0, the power-of-two path is used. Each half period of sclk lasts 2^(pow2_exp+1) source cycles (pow2_exp = 0 gives 2, pow2_exp = 3 gives 16).
- R4: With lin_sel = 1, the linear path is used. Each half period lasts lin_div+1 source cycles.
- R5: The lin_sel value sampled at the start of a transfer picks the path: 1 selects the linear path and 0 selects the power-of-two path.
- R6: The half-period counter restarts at the first edge that samples xfer_en high. sclk_tick is first high in the cycle after the H-th edge that follows the start edge, where H is the half period.
- R7: pow2_exp, lin_div, lin_sel and cpol are sampled only at the start edge. Changing them during a transfer has no effect on sclk or sclk_tick until xfer_en has been low for at least one edge.
- R8: During a transfer, sclk inverts exactly in the cycles in which sclk_tick is high, and holds its level in all other cycles.
- R9: At every edge that samples xfer_en low, sclk takes the value of cpol at that edge. Within one cycle it is therefore back at the idle polarity.
- R10: With the linear path and lin_div = 0, sclk_tick is high in every cycle after the start cycle, and sclk toggles on each source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | High while the transfer engine is running a transfer |
| cpol | input | 1 | Idle level of sclk |
| pow2_exp | input | 3 | Exponent E of the power-of-two path, divide by 2^(E+2) |
| lin_div | input | 8 | Value N of the linear path, divide by 2*(N+1) |
| lin_sel | input | 1 | 1 selects the linear path, 0 selects the power-of-two path |
| sclk | output | 1 | Registered serial clock level |
| sclk_tick | output | 1 | One-cycle pulse in each cycle in which sclk has just inverted |

## Verification
Both outputs come straight from registers, so every result is due exactly one edge after the inputs that cause it:

- The idle level of sclk follows cpol after one edge.
- The start edge produces no pulse.
- The first pulse appears H edges after the start edge.

The bench reference model advances on the same rising edge as the design, using the inputs that were stable before that edge. It compares sclk and sclk_tick on every falling edge, where both sides have settled. Inputs change only just after a rising edge, so neither the model nor the design sees a changing value at the edge.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    // Divider path chosen for one transfer
    typedef enum logic {
        PATH_POW2 = 1'b0,
        PATH_LIN  = 1'b1
    } path_e;

    // Half-period width needed for a power-of-two exponent of exp_w bits and a linear field of lin_w bits
    function automatic int half_width(input int exp_w, input int lin_w);
        int pw;
        pw = (1 << exp_w) + 1;
        return (pw > lin_w + 1) ? pw : lin_w + 1;
    endfunction

endpackage

// File: rtl/sclk_path_pow2.sv
module sclk_path_pow2 #(
    parameter int EXP_W  = 3,
    parameter int HALF_W = 9
) (
    input  logic [EXP_W-1:0]  exp_i,
    output logic [HALF_W-1:0] half_o
);
    // Full division is 2^(E+2), so a half period is 2^(E+1) source cycles
    logic [EXP_W:0] shamt;

    always_comb begin
        shamt  = {1'b0, exp_i} + {{EXP_W{1'b0}}, 1'b1};
        half_o = HALF_W'(1) << shamt;
    end
endmodule

// File: rtl/sclk_path_lin.sv
module sclk_path_lin #(
    parameter int LIN_W  = 8,
    parameter int HALF_W = 9
) (
    input  logic [LIN_W-1:0]  n_i,
    output logic [HALF_W-1:0] half_o
);
    // Full division is 2*(N+1), so a half period is N+1 source cycles
    always_comb begin
        half_o = HALF_W'(n_i) + HALF_W'(1);
    end
endmodule

// File: rtl/sclk_path_sel.sv
module sclk_path_sel
    import sclk_div_pkg::*;
#(
    parameter int EXP_W  = 3,
    parameter int LIN_W  = 8,
    parameter int HALF_W = 9
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [LIN_W-1:0]  n_i,
    input  path_e             path_i,
    output logic [HALF_W-1:0] half_o
);
    logic [HALF_W-1:0] half_pow2;
    logic [HALF_W-1:0] half_lin;

    sclk_path_pow2 #(.EXP_W(EXP_W), .HALF_W(HALF_W)) u_pow2 (
        .exp_i  (exp_i),
        .half_o (half_pow2)
    );

    sclk_path_lin #(.LIN_W(LIN_W), .HALF_W(HALF_W)) u_lin (
        .n_i    (n_i),
        .half_o (half_lin)
    );

    always_comb begin
        half_o = (path_i == PATH_LIN) ? half_lin : half_pow2;
    end
endmodule

// File: rtl/sclk_dual_div.sv
module sclk_dual_div
    import sclk_div_pkg::*;
#(
    parameter int EXP_W = 3,
    parameter int LIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_en,
    input  logic             cpol,
    input  logic [EXP_W-1:0] pow2_exp,
    input  logic [LIN_W-1:0] lin_div,
    input  logic             lin_sel,
    output logic             sclk,
    output logic             sclk_tick
);
    localparam int HALF_W = half_width(EXP_W, LIN_W);

    typedef struct packed {
        logic              run;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
        logic              sclk;
        logic              tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [HALF_W-1:0] half_cfg;
    logic [HALF_W-1:0] cnt_inc;
    path_e             path_cfg;

    assign path_cfg = lin_sel ? PATH_LIN : PATH_POW2;

    sclk_path_sel #(.EXP_W(EXP_W), .LIN_W(LIN_W), .HALF_W(HALF_W)) u_sel (
        .exp_i  (pow2_exp),
        .n_i    (lin_div),
        .path_i (path_cfg),
        .half_o (half_cfg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        cnt_inc   = st_q.cnt + HALF_W'(1);
        if (!xfer_en) begin
            // Idle: track configuration, rest at polarity
            st_d.run  = 1'b0;
            st_d.cnt  = '0;
            st_d.half = half_cfg;
            st_d.sclk = cpol;
        end else if (!st_q.run) begin
            // Start edge: freeze divisor, restart counter
            st_d.run  = 1'b1;
            st_d.cnt  = '0;
            st_d.half = half_cfg;
        end else if (cnt_inc == st_q.half) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
            st_d.sclk = ~st_q.sclk;
        end else begin
            st_d.cnt  = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.half <= HALF_W'(1);
        end else begin
            st_q      <= st_d;
        end
    end

    assign sclk      = st_q.sclk;
    assign sclk_tick = st_q.tick;
endmodule

// File: rtl/sclk_dual_div_chk.sv
module sclk_dual_div_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_en,
    input logic cpol,
    input logic sclk,
    input logic sclk_tick
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: no pulse after an idle edge
    a_r2_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(xfer_en)) |-> !sclk_tick);

    // R9: idle level follows polarity
    a_r9_idle_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(xfer_en)) |-> (sclk == $past(cpol)));

    // R8: a pulse means the level has just inverted
    a_r8_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sclk_tick) |-> (sclk != $past(sclk)));

    // R8: level holds during a transfer when there is no pulse
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(xfer_en) && !sclk_tick) |-> $stable(sclk));

    // R6: the start edge itself produces no pulse
    a_r6_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(xfer_en)) |=> !sclk_tick);
endmodule

bind sclk_dual_div sclk_dual_div_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_en   (xfer_en),
    .cpol      (cpol),
    .sclk      (sclk),
    .sclk_tick (sclk_tick)
);

// File: tb/test_sclk_dual_div.sv
module test_sclk_dual_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_en = 1'b0;
    logic       cpol = 1'b0;
    logic [2:0] pow2_exp = 3'd0;
    logic [7:0] lin_div = 8'd0;
    logic       lin_sel = 1'b0;
    logic       sclk;
    logic       sclk_tick;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Behavioural reference model state
    int m_half = 1;
    int m_elapsed = 0;
    bit m_run = 0;
    bit m_sclk = 0;
    bit m_tick = 0;
    bit prev_sclk = 0;

    always #2.5 clk = ~clk;

    sclk_dual_div i_sclk_dual_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_en   (xfer_en),
        .cpol      (cpol),
        .pow2_exp  (pow2_exp),
        .lin_div   (lin_div),
        .lin_sel   (lin_sel),
        .sclk      (sclk),
        .sclk_tick (sclk_tick)
    );

    function automatic int spec_half(bit sel, int e, int n);
        if (sel) return n + 1;
        return 2 ** (e + 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_sclk = 0; m_tick = 0; m_elapsed = 0;
        end else if (!xfer_en) begin
            m_run = 0; m_sclk = cpol; m_tick = 0; m_elapsed = 0;
        end else if (!m_run) begin
            m_run = 1; m_tick = 0; m_elapsed = 0;
            m_half = spec_half(lin_sel, int'(pow2_exp), int'(lin_div));
        end else begin
            m_elapsed++;
            m_tick = 0;
            if (m_elapsed == m_half) begin
                m_tick = 1; m_sclk = !m_sclk; m_elapsed = 0;
            end
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            check_bit("R1", "sclk in reset", sclk, 1'b0);
            check_bit("R1", "tick in reset", sclk_tick, 1'b0);
        end else begin
            check_bit(cur_req, "sclk", sclk, m_sclk);
            check_bit(cur_req, "sclk_tick", sclk_tick, m_tick);
            if (sclk_tick === 1'b1)
                check_bit("R8", "sclk inverted on tick", sclk, ~prev_sclk);
        end
        prev_sclk = sclk;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_xfer(string req, bit sel, int e, int n, bit pol, int len);
        cur_req = req;
        lin_sel = sel; pow2_exp = 3'(e); lin_div = 8'(n); cpol = pol;
        step(3);
        xfer_en = 1'b1;
        step(len);
        xfer_en = 1'b0;
        step(3);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        // R2 and R9: idle with polarity changes
        cur_req = "R2";
        step(3);
        cur_req = "R9";
        cpol = 1'b1; step(3);
        cpol = 1'b0; step(2);
        // R3 and R5: power-of-two path
        run_xfer("R3", 1'b0, 0, 9, 1'b0, 20);
        run_xfer("R3", 1'b0, 2, 9, 1'b1, 40);
        run_xfer("R5", 1'b0, 3, 0, 1'b0, 70);
        // R4 and R10: linear path
        run_xfer("R10", 1'b1, 5, 0, 1'b0, 12);
        run_xfer("R4", 1'b1, 0, 4, 1'b1, 30);
        run_xfer("R5", 1'b1, 7, 2, 1'b0, 20);
        // R7: change config and polarity mid-transfer
        cur_req = "R7";
        lin_sel = 1'b1; lin_div = 8'd2; cpol = 1'b1;
        step(2);
        xfer_en = 1'b1;
        step(5);
        lin_div = 8'd0; lin_sel = 1'b0; pow2_exp = 3'd1; cpol = 1'b0;
        step(20);
        xfer_en = 1'b0;
        step(2);
        // R6: back-to-back restart after one idle edge
        cur_req = "R6";
        lin_sel = 1'b1; lin_div = 8'd6;
        xfer_en = 1'b1; step(11);
        xfer_en = 1'b0; step(1);
        xfer_en = 1'b1; step(20);
        xfer_en = 1'b0; step(3);
        // R1: reset in mid-transfer
        cur_req = "R1";
        xfer_en = 1'b1; step(4);
        rst_n = 1'b0; xfer_en = 1'b0; step(2);
        rst_n = 1'b1; step(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule